// File: doc/BRIEF.md
# PCM Time-Slot Idle Code Inserter

This block sits in the transmit path of a 32-slot PCM frame and overwrites chosen time slots with a programmable idle byte. Bytes arrive one per slot, each qualified by a valid strobe. A frame-start flag marks the first byte of slot 0. A slot counter tracks the position within the frame. A 32-bit selection mask, an idle-code byte and a transparent-mode flag decide, for each slot, whether the byte passes through or is replaced.

Slot 0 carries framing information and gets extra protection. Its mask bit alone does not replace it: the transparent-mode flag must also be set. The mask, the idle code and the transparent flag are captured at each frame start, so a frame is never partly modified. The output stream keeps the input timing and is delayed by one registered stage.

Top module: `ts_idle_inserter`

## Requirements
- R1: While reset is high, and in the first cycle after it, out_valid and out_sof are 0 and out_data is 0x00.
- R2: out_valid equals in_valid of the previous clock cycle. out_sof is 1 exactly one cycle after a byte that had both in_valid and in_sof high.
- R3: The byte that carries the frame-start flag is slot 0. Each later valid byte is the next slot. Slot n is controlled by bit n of sel_mask, where bit 0 is the least significant bit.
- R4: When the mask bit of a slot is 0, the byte appears unchanged on out_data.
- R5: When the mask bit of a slot from 1 to 31 is 1, out_data carries the idle code in place of the byte.
- R6: When mask bit 0 is 1 and xparent_en is 0, slot 0 passes through unchanged.
- R7: When mask bit 0 is 1 and xparent_en is 1, slot 0 is replaced with the idle code.
- R8: sel_mask, idle_code and xparent_en are sampled on the frame-start byte. Changes made later in the frame have no effect until the next frame start.
- R9: A cycle with in_valid low does not advance the slot position, and out_data holds its last value in the following cycle.
- R10: If no frame-start flag arrives, the slot position wraps from 31 back to 0 and slot 0's rules apply again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte strobe |
| in_sof | input | 1 | Frame start; qualifies the slot-0 byte |
| in_data | input | 8 | Input slot byte |
| sel_mask | input | 32 | Per-slot substitution select, bit n controls slot n |
| idle_code | input | 8 | Replacement byte |
| xparent_en | input | 1 | Allows substitution of slot 0 |
| out_valid | output | 1 | Output byte strobe |
| out_sof | output | 1 | Output frame start |
| out_data | output | 8 | Output slot byte |

## Verification
Every output byte, its valid strobe and its frame-start flag are due exactly one clock after the input byte that produced them. Gaps in the input add no further delay. The driver computes each expected byte with its own slot count and its own copy of the configuration, captured at frame start. It then queues the result. The monitor samples on the falling edge that follows each rising edge, so it pairs each out_valid with the oldest queued item. In cycles where out_valid is low, it checks that out_data still holds its last value.

// File: rtl/ts_idle_pkg.sv
package ts_idle_pkg;

    localparam int DEF_SLOTS  = 32;
    localparam int DEF_BYTE_W = 8;

    // Per-slot decision carried from the selector to the output stage
    typedef enum logic [1:0] {
        CLS_PASS  = 2'd0,   // mask bit clear
        CLS_FILL  = 2'd1,   // replaced by idle code
        CLS_GUARD = 2'd2    // slot 0 selected but protected
    } slot_cls_e;

    function automatic logic cls_replaces(slot_cls_e c);
        return (c == CLS_FILL);
    endfunction

endpackage

// File: rtl/ts_slot_tracker.sv
module ts_slot_tracker #(
    parameter int SLOTS = ts_idle_pkg::DEF_SLOTS,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              beat,
    input  logic              sof,
    output logic [SLOT_W-1:0] cur_slot
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);
    localparam logic [SLOT_W-1:0] ONE  = SLOT_W'(1);

    logic [SLOT_W-1:0] cnt_q;
    logic [SLOT_W-1:0] cnt_after;

    // frame start forces slot 0 for the current byte
    assign cur_slot = sof ? '0 : cnt_q;

    always_comb begin
        if (cur_slot == LAST) cnt_after = '0;
        else                  cnt_after = cur_slot + ONE;
    end

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (beat) cnt_q <= cnt_after;
    end
endmodule

// File: rtl/ts_cfg_shadow.sv
module ts_cfg_shadow #(
    parameter int SLOTS  = ts_idle_pkg::DEF_SLOTS,
    parameter int BYTE_W = ts_idle_pkg::DEF_BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [SLOTS-1:0]  live_mask,
    input  logic [BYTE_W-1:0] live_idle,
    input  logic              live_xp,
    output logic [SLOTS-1:0]  eff_mask,
    output logic [BYTE_W-1:0] eff_idle,
    output logic              eff_xp
);
    logic [SLOTS-1:0]  mask_q;
    logic [BYTE_W-1:0] idle_q;
    logic              xp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            idle_q <= '0;
            xp_q   <= 1'b0;
        end else if (load) begin
            mask_q <= live_mask;
            idle_q <= live_idle;
            xp_q   <= live_xp;
        end
    end

    // the frame-start byte itself already obeys the new settings
    assign eff_mask = load ? live_mask : mask_q;
    assign eff_idle = load ? live_idle : idle_q;
    assign eff_xp   = load ? live_xp   : xp_q;
endmodule

// File: rtl/ts_slot_selector.sv
module ts_slot_selector
    import ts_idle_pkg::*;
#(
    parameter int SLOTS = ts_idle_pkg::DEF_SLOTS,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic [SLOTS-1:0]  mask,
    input  logic              xparent,
    input  logic [SLOT_W-1:0] slot,
    output slot_cls_e         cls
);
    logic [SLOTS-1:0] fill_vec;
    logic [SLOTS-1:0] guard_vec;

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        if (i == 0) begin : g_head
            assign fill_vec[i]  = mask[i] &  xparent;
            assign guard_vec[i] = mask[i] & ~xparent;
        end else begin : g_body
            assign fill_vec[i]  = mask[i];
            assign guard_vec[i] = 1'b0;
        end
    end

    always_comb begin
        if (fill_vec[slot])       cls = CLS_FILL;
        else if (guard_vec[slot]) cls = CLS_GUARD;
        else                      cls = CLS_PASS;
    end
endmodule

// File: rtl/ts_byte_out.sv
module ts_byte_out
    import ts_idle_pkg::*;
#(
    parameter int BYTE_W = ts_idle_pkg::DEF_BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              beat,
    input  logic              sof,
    input  logic [BYTE_W-1:0] data,
    input  logic [BYTE_W-1:0] idle,
    input  slot_cls_e         cls,
    output logic              o_valid,
    output logic              o_sof,
    output logic [BYTE_W-1:0] o_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            o_valid <= 1'b0;
            o_sof   <= 1'b0;
            o_data  <= '0;
        end else begin
            o_valid <= beat;
            o_sof   <= beat & sof;
            if (beat) o_data <= cls_replaces(cls) ? idle : data;
        end
    end
endmodule

// File: rtl/ts_idle_inserter.sv
module ts_idle_inserter
    import ts_idle_pkg::*;
#(
    parameter int SLOTS  = ts_idle_pkg::DEF_SLOTS,
    parameter int BYTE_W = ts_idle_pkg::DEF_BYTE_W,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic [BYTE_W-1:0] in_data,
    input  logic [SLOTS-1:0]  sel_mask,
    input  logic [BYTE_W-1:0] idle_code,
    input  logic              xparent_en,
    output logic              out_valid,
    output logic              out_sof,
    output logic [BYTE_W-1:0] out_data
);
    logic              frame_load;
    logic [SLOT_W-1:0] slot_now;
    logic [SLOTS-1:0]  mask_eff;
    logic [BYTE_W-1:0] idle_eff;
    logic              xp_eff;
    slot_cls_e         cls_now;

    assign frame_load = in_valid & in_sof;

    ts_slot_tracker #(.SLOTS(SLOTS)) u_trk (
        .clk(clk), .rst(rst), .beat(in_valid), .sof(in_sof), .cur_slot(slot_now)
    );

    ts_cfg_shadow #(.SLOTS(SLOTS), .BYTE_W(BYTE_W)) u_cfg (
        .clk(clk), .rst(rst), .load(frame_load),
        .live_mask(sel_mask), .live_idle(idle_code), .live_xp(xparent_en),
        .eff_mask(mask_eff), .eff_idle(idle_eff), .eff_xp(xp_eff)
    );

    ts_slot_selector #(.SLOTS(SLOTS)) u_sel (
        .mask(mask_eff), .xparent(xp_eff), .slot(slot_now), .cls(cls_now)
    );

    ts_byte_out #(.BYTE_W(BYTE_W)) u_out (
        .clk(clk), .rst(rst), .beat(in_valid), .sof(in_sof), .data(in_data),
        .idle(idle_eff), .cls(cls_now),
        .o_valid(out_valid), .o_sof(out_sof), .o_data(out_data)
    );
endmodule

// File: rtl/ts_idle_chk.sv
module ts_idle_chk #(
    parameter int SLOTS  = 32,
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_sof,
    input logic [BYTE_W-1:0] in_data,
    input logic [SLOTS-1:0]  sel_mask,
    input logic [BYTE_W-1:0] idle_code,
    input logic              xparent_en,
    input logic              out_valid,
    input logic              out_sof,
    input logic [BYTE_W-1:0] out_data
);
    // R2
    valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R2
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R2
    sof_qual_chk: assert property (@(posedge clk) disable iff (rst)
        out_sof |-> out_valid);
    // R9
    gap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data));
    // R4
    head_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sof && !sel_mask[0]) |=> (out_data == $past(in_data)));
    // R6
    head_guard_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sof && sel_mask[0] && !xparent_en) |=> (out_data == $past(in_data)));
    // R7
    head_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sof && sel_mask[0] && xparent_en) |=> (out_data == $past(idle_code)));
endmodule

bind ts_idle_inserter ts_idle_chk #(.SLOTS(SLOTS), .BYTE_W(BYTE_W)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data),
    .sel_mask(sel_mask), .idle_code(idle_code), .xparent_en(xparent_en),
    .out_valid(out_valid), .out_sof(out_sof), .out_data(out_data)
);

// File: tb/sim_ts_idle_inserter.sv
module sim_ts_idle_inserter;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 100000;

    typedef struct {
        logic [7:0] d;
        logic       s;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_sof = 1'b0;
    logic [7:0]  in_data = '0;
    logic [31:0] sel_mask = '0;
    logic [7:0]  idle_code = '0;
    logic        xparent_en = 1'b0;
    logic        out_valid;
    logic        out_sof;
    logic [7:0]  out_data;

    int   n_checks = 0;
    int   n_fails  = 0;
    bit   done     = 1'b0;
    exp_t sb[$];

    // bench reference state
    int          m_slot = 0;
    logic [31:0] m_mask = '0;
    logic [7:0]  m_idle = '0;
    logic        m_xp   = 1'b0;
    logic [7:0]  last_out = '0;

    ts_idle_inserter u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data),
        .sel_mask(sel_mask), .idle_code(idle_code), .xparent_en(xparent_en),
        .out_valid(out_valid), .out_sof(out_sof), .out_data(out_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s act=0x%0h exp=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    // driver: one valid byte, expected result queued from the reference model
    task automatic send_byte(input logic [7:0] d, input bit s, input string extra);
        exp_t  e;
        int    slot;
        bit    sel;
        string tag;
        @(posedge clk); #1;
        in_valid = 1'b1;
        in_sof   = s;
        in_data  = d;
        if (s) begin
            m_slot = 0;
            m_mask = sel_mask;
            m_idle = idle_code;
            m_xp   = xparent_en;
        end
        slot = m_slot;
        sel  = m_mask[slot];
        if (!sel)           begin e.d = d;      tag = "R4"; end
        else if (slot != 0) begin e.d = m_idle; tag = "R5"; end
        else if (m_xp)      begin e.d = m_idle; tag = "R7"; end
        else                begin e.d = d;      tag = "R6"; end
        e.s   = s;
        e.tag = {tag, " ", extra};
        sb.push_back(e);
        m_slot = (slot + 1) % 32;
    endtask

    task automatic gap(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            in_valid = 1'b0;
            in_sof   = $urandom_range(0, 1);
            in_data  = 8'($urandom);
        end
    endtask

    task automatic send_frame(input string extra, input int gap_pct);
        for (int k = 0; k < 32; k++) begin
            send_byte(8'($urandom), (k == 0), extra);
            if (gap_pct > 0 && $urandom_range(0, 99) < gap_pct) gap($urandom_range(1, 3));
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R2 unexpected out_valid", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(out_data == e.d, e.tag, 32'(out_data), 32'(e.d));
                    check(out_sof == e.s, "R2 out_sof", 32'(out_sof), 32'(e.s));
                end
                last_out = out_data;
            end else begin
                check(out_data == last_out, "R9 hold", 32'(out_data), 32'(last_out));
            end
        end
    end

    // watchdog
    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired act=0x0 exp=0x1");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        in_valid = 1'b1; in_sof = 1'b1; in_data = 8'hA5;
        sel_mask = '1; idle_code = 8'h3C; xparent_en = 1'b1;
        @(negedge clk);
        // R1 outputs stay cleared under reset even with active inputs
        check(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 32'd0);
        check(out_sof == 1'b0, "R1 out_sof", 32'(out_sof), 32'd0);
        check(out_data == 8'h00, "R1 out_data", 32'(out_data), 32'd0);
        @(posedge clk); #1;
        in_valid = 1'b0; in_sof = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0 && out_data == 8'h00, "R1 after release",
              {out_valid, 23'd0, out_data}, 32'd0);

        // R4 all slots pass
        sel_mask = '0; idle_code = 8'hFF; xparent_en = 1'b1;
        send_frame("mask0", 0);
        send_frame("mask0", 0);

        // R5 R6 every slot selected, slot 0 protected
        sel_mask = '1; idle_code = 8'h7E; xparent_en = 1'b0;
        send_frame("allsel", 0);
        // R7 slot 0 released by transparent mode
        xparent_en = 1'b1; idle_code = 8'h55;
        send_frame("allsel_xp", 0);

        // R3 single-bit masks locate the right slot
        xparent_en = 1'b1;
        for (int b = 0; b < 32; b += 5) begin
            sel_mask = 32'd1 << b; idle_code = 8'(b + 8'h90);
            send_frame("R3", 0);
        end
        sel_mask = 32'h8000_0001; idle_code = 8'hC3;
        send_frame("R3", 0);

        // R8 mid-frame change ignored until next frame start
        sel_mask = 32'h0000_FF00; idle_code = 8'h11; xparent_en = 1'b0;
        for (int k = 0; k < 32; k++) begin
            if (k == 4) begin
                sel_mask = 32'hFFFF_00FF; idle_code = 8'h22; xparent_en = 1'b1;
            end
            send_byte(8'($urandom), (k == 0), "R8");
        end
        send_frame("R8 next", 0);

        // R9 gaps between bytes
        sel_mask = 32'hA5A5_5A5A; idle_code = 8'h99; xparent_en = 1'b1;
        send_frame("R9", 40);
        gap(4);
        send_frame("R9", 60);

        // R10 wrap without frame start
        sel_mask = 32'h0000_0003; idle_code = 8'h44; xparent_en = 1'b1;
        send_frame("R10", 0);
        for (int k = 0; k < 32; k++) send_byte(8'($urandom), 1'b0, "R10");
        xparent_en = 1'b0;
        for (int k = 0; k < 32; k++) send_byte(8'($urandom), 1'b0, "R10");

        // random frames
        for (int f = 0; f < 40; f++) begin
            sel_mask = $urandom; idle_code = 8'($urandom); xparent_en = $urandom_range(0, 1);
            send_frame("rand", 20);
        end

        gap(4);
        @(negedge clk);
        check(sb.size() == 0, "R2 missing outputs", 32'(sb.size()), 32'd0);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule